// File: doc/BRIEF.md
# Processor Status Word Register

This block stores the 16-bit status word of a small processor core. The low byte holds five condition flags: carry, overflow, zero, negative and extend. The high byte holds the system control fields: a three-level interrupt priority mask, the supervisor bit and the trace bit. The block does not compute flags or decode instructions. It stores the word, merges flag updates from the ALU, accepts software writes, and stops user-mode code from changing the system byte.

Each ALU operation brings a five-bit update enable and four new flag values. Each flag changes only when its own enable is set. The extend flag has no value input of its own. When its enable is set, it takes the new carry value, so a later operation can change carry and leave extend as it was.

Software writes either the low byte alone or the whole word. A whole-word write made while the supervisor bit is clear is cut down to a low-byte write, and the block raises a one-cycle privilege-violation pulse. While the trace bit is set, each completed instruction produces a one-cycle trace request.

Top module: `psw_unit`

## Requirements
- R1: Synchronous reset loads the status word 0x2700 (supervisor set, mask 111, trace and all flags clear). After reset, `priv_viol_o` and `trace_req_o` are 0.
- R2: The flags sit at fixed bit positions: carry bit 0, overflow bit 1, zero bit 2, negative bit 3. Flag i takes `alu_flags_i[i]` at the clock edge when `alu_upd_i[i]` is 1. Otherwise it holds its value.
- R3: The extend flag sits at bit 4. When `alu_upd_i[4]` is 1, it takes the new carry value `alu_flags_i[0]`. When `alu_upd_i[4]` is 0, it holds its value, whatever happens to carry.
- R4: A low-byte write (`wr_en_i`=1, `wr_full_i`=0) loads `wr_data_i[4:0]` into bits 4..0 in either mode. It leaves the high byte unchanged and raises no violation.
- R5: A whole-word write (`wr_en_i`=1, `wr_full_i`=1) made while the supervisor bit is set loads the user byte and bits 10..8 (mask), 13 (supervisor) and 15 (trace). `ipl_mask_o`, `super_o` and `trace_o` show those bits.
- R6: A whole-word write made while the supervisor bit is clear updates only the low byte and leaves bits 15..8 unchanged. `priv_viol_o` is 1 for exactly the cycle after that write.
- R7: Bits 5, 6, 7, 11, 12 and 14 always read 0, whatever is written.
- R8: When a software write and an ALU update fall in the same cycle, the written value wins for the low byte.
- R9: `trace_req_o` is 1 in the cycle after `instr_done_i`=1 if the trace bit was set when `instr_done_i` was sampled. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd_i | input | 5 | Per-flag update enables, bit order C,V,Z,N,X (bit 0 = C) |
| alu_flags_i | input | 4 | New flag values, bit order C,V,Z,N |
| wr_en_i | input | 1 | Software write strobe |
| wr_full_i | input | 1 | 1 = whole-word write, 0 = low byte only |
| wr_data_i | input | 16 | Write data |
| instr_done_i | input | 1 | An instruction completed this cycle |
| status_o | output | 16 | Full status word |
| flags_o | output | 5 | Flags X,N,Z,V,C (bit 0 = C) |
| ipl_mask_o | output | 3 | Interrupt priority mask |
| super_o | output | 1 | Supervisor bit |
| trace_o | output | 1 | Trace bit |
| priv_viol_o | output | 1 | One-cycle privilege-violation pulse |
| trace_req_o | output | 1 | One-cycle trace request |

## Verification
A software write and an ALU flag update can fall in the same cycle, and the outcome then depends on which one owns the low byte. The bench drives both together with differing low-byte values, and expects the written byte, not the ALU result. A whole-word write from user mode also produces a register update and a violation pulse in the same cycle. The bench checks the trimmed word and the pulse at the same sample, then confirms that the pulse is gone one cycle later.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 5;
  localparam int MASK_W = 3;

  localparam int C_BIT    = 0;
  localparam int X_BIT    = 4;
  localparam int MASK_LSB = 8;
  localparam int S_BIT    = 13;
  localparam int T_BIT    = 15;

  localparam logic [PSW_W-1:0] USER_KEEP  = 16'h001F;
  localparam logic [PSW_W-1:0] SYS_KEEP   = 16'hA700;
  localparam logic [PSW_W-1:0] RESET_WORD = 16'h2700;
endpackage

// File: rtl/psw_user_byte.sv
module psw_user_byte
  import psw_pkg::*;
(
  input  logic [BYTE_W-1:0] cur_i,
  input  logic [FLAG_N-1:0] upd_i,
  input  logic [FLAG_N-2:0] val_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] nxt_o
);
  logic [BYTE_W-1:0] alu_nxt;

  // Arithmetic flags: each has its own enable and its own value input
  for (genvar g = 0; g < FLAG_N - 1; g++) begin : g_flag
    assign alu_nxt[g] = upd_i[g] ? val_i[g] : cur_i[g];
  end

  // Extend follows carry, but only when its own enable is set
  assign alu_nxt[X_BIT] = upd_i[X_BIT] ? val_i[C_BIT] : cur_i[X_BIT];
  assign alu_nxt[BYTE_W-1:FLAG_N] = '0;

  // A software write takes precedence over the ALU
  assign nxt_o = wr_i ? (wdata_i & USER_KEEP[BYTE_W-1:0]) : alu_nxt;
endmodule

// File: rtl/psw_sys_byte.sv
module psw_sys_byte
  import psw_pkg::*;
(
  input  logic [BYTE_W-1:0] cur_i,
  input  logic              super_i,
  input  logic              wr_full_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              viol_o
);
  localparam logic [BYTE_W-1:0] KEEP = SYS_KEEP[PSW_W-1:BYTE_W];

  logic grant;

  assign grant  = wr_full_i & super_i;
  assign viol_o = wr_full_i & ~super_i;
  assign nxt_o  = grant ? (wdata_i & KEEP) : (cur_i & KEEP);
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] alu_upd_i,
  input  logic [FLAG_N-2:0] alu_flags_i,
  input  logic              wr_en_i,
  input  logic              wr_full_i,
  input  logic [PSW_W-1:0]  wr_data_i,
  input  logic              instr_done_i,
  output logic [PSW_W-1:0]  status_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [MASK_W-1:0] ipl_mask_o,
  output logic              super_o,
  output logic              trace_o,
  output logic              priv_viol_o,
  output logic              trace_req_o
);
  logic [PSW_W-1:0]  status_q;
  logic [BYTE_W-1:0] user_nxt;
  logic [BYTE_W-1:0] sys_nxt;
  logic              viol_nxt;
  logic              viol_q;
  logic              trace_req_q;

  psw_user_byte u_user (
    .cur_i   (status_q[BYTE_W-1:0]),
    .upd_i   (alu_upd_i),
    .val_i   (alu_flags_i),
    .wr_i    (wr_en_i),
    .wdata_i (wr_data_i[BYTE_W-1:0]),
    .nxt_o   (user_nxt)
  );

  psw_sys_byte u_sys (
    .cur_i     (status_q[PSW_W-1:BYTE_W]),
    .super_i   (status_q[S_BIT]),
    .wr_full_i (wr_en_i & wr_full_i),
    .wdata_i   (wr_data_i[PSW_W-1:BYTE_W]),
    .nxt_o     (sys_nxt),
    .viol_o    (viol_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q    <= RESET_WORD;
      viol_q      <= 1'b0;
      trace_req_q <= 1'b0;
    end else begin
      status_q    <= {sys_nxt, user_nxt};
      viol_q      <= viol_nxt;
      // The trace bit is sampled as it stood when the instruction completed
      trace_req_q <= status_q[T_BIT] & instr_done_i;
    end
  end

  assign status_o    = status_q;
  assign flags_o     = status_q[FLAG_N-1:0];
  assign ipl_mask_o  = status_q[MASK_LSB+MASK_W-1:MASK_LSB];
  assign super_o     = status_q[S_BIT];
  assign trace_o     = status_q[T_BIT];
  assign priv_viol_o = viol_q;
  assign trace_req_o = trace_req_q;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  alu_upd_i,
  input logic        wr_en_i,
  input logic        wr_full_i,
  input logic        instr_done_i,
  input logic [15:0] status_o,
  input logic        super_o,
  input logic        trace_o,
  input logic        priv_viol_o,
  input logic        trace_req_o
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  AST_RESET_WORD: assert property (@(posedge clk) rst_d |-> (status_o == 16'h2700 && !priv_viol_o && !trace_req_o)); // R1

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !alu_upd_i[4]) |=> $stable(status_o[4])); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && alu_upd_i == 5'd0) |=> $stable(status_o)); // R2

  AST_LOW_WRITE_SYS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_full_i) |=> ($stable(status_o[15:8]) && !priv_viol_o)); // R4

  AST_USER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_full_i && !super_o) |=> ($stable(status_o[15:8]) && priv_viol_o)); // R6

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    priv_viol_o |-> $past(wr_en_i && wr_full_i && !super_o)); // R6

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_o & 16'h58E0) == 16'h0000); // R7

  AST_TRACE_REQ: assert property (@(posedge clk) disable iff (rst)
    (trace_o && instr_done_i) |=> trace_req_o); // R9

  AST_TRACE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(trace_o && instr_done_i) |=> !trace_req_o); // R9
endmodule

bind psw_unit psw_unit_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .alu_upd_i    (alu_upd_i),
  .wr_en_i      (wr_en_i),
  .wr_full_i    (wr_full_i),
  .instr_done_i (instr_done_i),
  .status_o     (status_o),
  .super_o      (super_o),
  .trace_o      (trace_o),
  .priv_viol_o  (priv_viol_o),
  .trace_req_o  (trace_req_o)
);

// File: tb/psw_unit_tb.sv
`timescale 1ns/1ps
module psw_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  alu_upd = '0;
  logic [3:0]  alu_flags = '0;
  logic        wr_en = 1'b0;
  logic        wr_full = 1'b0;
  logic [15:0] wr_data = '0;
  logic        instr_done = 1'b0;
  logic [15:0] status;
  logic [4:0]  flags;
  logic [2:0]  ipl_mask;
  logic        super_b, trace_b, priv_viol, trace_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_word = 16'h2700;
  logic        exp_viol = 1'b0;

  always #2 clk = ~clk;

  psw_unit dut_i (
    .clk(clk), .rst(rst), .alu_upd_i(alu_upd), .alu_flags_i(alu_flags),
    .wr_en_i(wr_en), .wr_full_i(wr_full), .wr_data_i(wr_data),
    .instr_done_i(instr_done), .status_o(status), .flags_o(flags),
    .ipl_mask_o(ipl_mask), .super_o(super_b), .trace_o(trace_b),
    .priv_viol_o(priv_viol), .trace_req_o(trace_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected next word, worked out from the requirements
  function automatic logic [15:0] model(input logic [15:0] cur, input logic [4:0] upd,
      input logic [3:0] val, input logic we, input logic full, input logic [15:0] d);
    logic [15:0] n = cur;
    for (int i = 0; i < 4; i++) if (upd[i]) n[i] = val[i];
    if (upd[4]) n[4] = val[0];
    if (we) begin
      n[7:0] = d[7:0] & 8'h1F;
      if (full && cur[13]) n[15:8] = d[15:8] & 8'hA7;
    end
    return n;
  endfunction

  // Apply one cycle of stimulus, then compare the word and the violation pulse
  task automatic step(input logic [4:0] u, input logic [3:0] v, input logic we,
      input logic full, input logic [15:0] d, input string tag);
    alu_upd = u; alu_flags = v; wr_en = we; wr_full = full; wr_data = d;
    exp_viol = we & full & ~exp_word[13];
    exp_word = model(exp_word, u, v, we, full, d);
    @(posedge clk); @(negedge clk);
    alu_upd = '0; wr_en = 1'b0; wr_full = 1'b0;
    chk(status == exp_word, tag, status, exp_word);
    chk(priv_viol == exp_viol, {tag, " viol"}, {15'd0, priv_viol}, {15'd0, exp_viol});
    chk((status & 16'h58E0) == 16'h0, "R7 spare bits", status, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(status == 16'h2700, "R1 reset word", status, 16'h2700);
    chk(!priv_viol && !trace_req, "R1 pulses idle", {14'd0, priv_viol, trace_req}, 16'h0);
    chk(ipl_mask == 3'b111 && super_b && !trace_b, "R1 fields",
        {11'd0, trace_b, super_b, ipl_mask}, 16'h0007 | 16'h0008);

    // R2/R3: sweep every enable pattern against every flag value
    for (int e = 0; e < 32; e++)
      for (int v = 0; v < 16; v++)
        step(e[4:0], v[3:0], 1'b0, 1'b0, 16'h0, (e[4] ? "R3 extend update" : "R2 flag update"));

    // R3: carry changes while extend must hold
    step(5'b10001, 4'h1, 1'b0, 1'b0, 16'h0, "R3 set C and X");
    step(5'b00001, 4'h0, 1'b0, 1'b0, 16'h0, "R3 C cleared X held");
    chk(flags[4] == 1'b1 && flags[0] == 1'b0, "R3 extend kept", {11'd0, flags}, 16'h0010);

    // R4: low-byte writes, all values, supervisor mode
    for (int b = 0; b < 256; b++)
      step(5'd0, 4'd0, 1'b1, 1'b0, {8'hFF, b[7:0]}, "R4 low write");

    // R5: whole-word writes keeping supervisor set
    for (int h = 0; h < 256; h++) begin
      step(5'd0, 4'd0, 1'b1, 1'b1, {h[7:0] | 8'h20, 8'hFF}, "R5 full write");
      chk(ipl_mask == exp_word[10:8] && super_b == exp_word[13] && trace_b == exp_word[15],
          "R5 field outputs", {11'd0, trace_b, super_b, ipl_mask}, exp_word);
    end

    // R8: write and ALU update in one cycle
    step(5'b11111, 4'hF, 1'b1, 1'b0, 16'h0005, "R8 write wins");
    step(5'b11111, 4'h0, 1'b1, 1'b1, 16'h271A, "R8 write wins full");

    // R9: trace request
    step(5'd0, 4'd0, 1'b1, 1'b1, 16'hA000, "R9 set trace");
    instr_done = 1'b1; @(posedge clk); @(negedge clk); instr_done = 1'b0;
    chk(trace_req == 1'b1, "R9 request raised", {15'd0, trace_req}, 16'h1);
    @(posedge clk); @(negedge clk);
    chk(trace_req == 1'b0, "R9 request one cycle", {15'd0, trace_req}, 16'h0);
    step(5'd0, 4'd0, 1'b1, 1'b1, 16'h2000, "R9 clear trace");
    instr_done = 1'b1; @(posedge clk); @(negedge clk); instr_done = 1'b0;
    chk(trace_req == 1'b0, "R9 no request untraced", {15'd0, trace_req}, 16'h0);

    // R5/R6: drop to user, then attempt system writes
    step(5'd0, 4'd0, 1'b1, 1'b1, 16'h0003, "R5 leave supervisor");
    chk(!super_b, "R5 user mode", {15'd0, super_b}, 16'h0);
    step(5'd0, 4'd0, 1'b1, 1'b1, 16'hA7FF, "R6 user full write");
    chk(priv_viol == 1'b1, "R6 pulse", {15'd0, priv_viol}, 16'h1);
    @(posedge clk); @(negedge clk);
    chk(priv_viol == 1'b0, "R6 pulse one cycle", {15'd0, priv_viol}, 16'h0);
    step(5'd0, 4'd0, 1'b1, 1'b0, 16'hFF0A, "R4 user low write");
    for (int h = 0; h < 16; h++)
      step(5'd0, 4'd0, 1'b1, 1'b1, {h[3:0], 4'hF, 8'h11 + h[7:0]}, "R6 user sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule